// File: doc/BRIEF.md
# NMI Edge Capture and Status Word

This block watches an asynchronous non-maskable interrupt pin and turns a chosen transition on it into two independent records. The first is a request line to the processor, which stays high until the processor signals acceptance. The second is a sticky flag in a 32-bit status word that software reads and clears. A configuration input chooses whether a low-to-high or a high-to-low transition counts as an event.

The pin first passes through a chain of synchronizer flops. Event detection compares two consecutive synchronized samples. Detection stays disabled until the chain holds real samples after reset, so the pin level present at reset is never reported as an event.

The request and the flag are kept apart on purpose. Processor acceptance drops the request and leaves the flag set. A software clear drops the flag and leaves the request pending. A new event in the same cycle as either clear wins over it. The status word also shows the synchronized pin level in its top bit. Every other bit apart from the flag reads as zero.

Top module: `nmi_status_unit`

## Requirements
- R1: While reset is asserted and directly after it, the flag (bit 16) and `cpu_req_o` are 0, and with the pin held low the whole status word reads 0.
- R2: Bit 31 of `reg_rdata_o` equals the pin level two clock edges after the pin changes. Writes do not alter it.
- R3: With `edge_sel_i`=1 a 0→1 pin transition is an event, and with `edge_sel_i`=0 a 1→0 transition is an event. An event sets bit 16 and `cpu_req_o`, both visible three clock edges after the pin changes. The opposite transition sets neither.
- R4: Once set, the flag holds until a write with `reg_we_i`=1 and `reg_wdata_i[16]`=0. Acknowledges and pin activity do not clear it, and that write clears it at the next edge.
- R5: A write with bit 16 set to 1 never sets the flag. Only an event sets it.
- R6: `cpu_ack_i` high for one cycle drops a pending `cpu_req_o` at the next edge and leaves the flag unchanged.
- R7: A software clear-write does not drop a pending `cpu_req_o`.
- R8: Bits 30..17 and 15..0 of `reg_rdata_o` always read 0, whatever value was written.
- R9: An event in the same cycle as a clear-write leaves the flag at 1. An event in the same cycle as an acknowledge leaves `cpu_req_o` at 1.
- R10: No event is reported during the first SYNC_STAGES+1 edges after reset. A pin already high at reset release in rising mode gives neither flag nor request.
- R11: The flag has no effect on requests. An event with the flag already set still raises `cpu_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_pin_i | input | 1 | Asynchronous NMI pin |
| edge_sel_i | input | 1 | 1: rising-edge events, 0: falling-edge events |
| reg_we_i | input | 1 | Status word write strobe |
| reg_wdata_i | input | 32 | Write data; only bit 16 is acted on |
| reg_rdata_o | output | 32 | Status word: bit 31 pin level, bit 16 flag |
| cpu_req_o | output | 1 | Pending NMI request to the processor |
| cpu_ack_i | input | 1 | Processor acceptance of the request |

## Verification
The assertions assume `edge_sel_i` is quasi-static. They also assume the write and acknowledge strobes are synchronous to `clk` and treat each cycle they are high as one request. The bench changes every input only on the falling clock edge. It changes the pin only after the synchronizer has settled, and it changes `edge_sel_i` only while the pin is steady. Coincident-event cases are produced by timing a strobe into the single cycle in which the detected event is live.

// File: rtl/nmi_status_pkg.sv
package nmi_status_pkg;
  localparam int REG_W     = 32;
  localparam int LEVEL_POS = 31;
  localparam int FLAG_POS  = 16;

  // event rule: transition between two consecutive synchronized samples
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  // status word assembly: only level and flag positions carry data
  function automatic logic [REG_W-1:0] pack_status(input logic lvl, input logic flg);
    logic [REG_W-1:0] w;
    w = '0;
    w[LEVEL_POS] = lvl;
    w[FLAG_POS]  = flg;
    return w;
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge
  import nmi_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic rising_i,
  output logic event_o
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic          prev_q;
  logic [CW-1:0] warm_q;
  logic          primed;

  assign primed = (warm_q == CW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      warm_q <= '0;
    end else begin
      prev_q <= level_i;
      if (!primed) warm_q <= warm_q + 1'b1;
    end
  end

  assign event_o = primed & edge_hit(level_i, prev_q, rising_i);
endmodule

// File: rtl/nmi_track.sv
module nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clr_wr_i,
  input  logic ack_i,
  output logic flag_o,
  output logic req_o
);
  logic flag_q, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (event_i)       flag_q <= 1'b1;
      else if (clr_wr_i) flag_q <= 1'b0;
      if (event_i)       req_q  <= 1'b1;
      else if (ack_i)    req_q  <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = req_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wr_i |=> flag_q); // R4
  AST_FLAG_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !event_i |=> !flag_q); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> flag_q && req_q); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && ack_i && !event_i |=> !req_q); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack_i |=> req_q); // R7
endmodule

// File: rtl/nmi_status_unit.sv
module nmi_status_unit
  import nmi_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin_i,
  input  logic             edge_sel_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             cpu_req_o,
  input  logic             cpu_ack_i
);
  logic pin_sync;
  logic nmi_event;
  logic sw_clear;
  logic flag;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(nmi_pin_i), .sync_o(pin_sync)
  );

  nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pin_sync), .rising_i(edge_sel_i),
    .event_o(nmi_event)
  );

  assign sw_clear = reg_we_i & ~reg_wdata_i[FLAG_POS];

  nmi_track u_track (
    .clk(clk), .rst_n(rst_n), .event_i(nmi_event), .clr_wr_i(sw_clear),
    .ack_i(cpu_ack_i), .flag_o(flag), .req_o(cpu_req_o)
  );

  assign reg_rdata_o = pack_status(pin_sync, flag);

  AST_REQ_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_event |=> cpu_req_o && reg_rdata_o[FLAG_POS]); // R11
endmodule

// File: tb/nmi_status_unit_tb.sv
module nmi_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        sel = 1'b1;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic        ack = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  nmi_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin_i(pin), .edge_sel_i(sel),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_req_o(req), .cpu_ack_i(ack)
  );

  function automatic logic [31:0] word(input logic lvl, input logic flg);
    return 32'(lvl) * 32'h8000_0000 + 32'(flg) * 32'h0001_0000;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    we = 1'b1; wdata = '0; ack = 1'b1;
    step(1);
    we = 1'b0; ack = 1'b0;
  endtask

  initial begin
    // R10: pin high through reset, rising mode
    step(3);
    chk("R1 word in reset", rdata, 32'h0);
    chk("R1 req in reset", 32'(req), 32'h0);
    rst_n = 1'b1;
    step(6);
    chk("R10 word after warm-up", rdata, word(1'b1, 1'b0));
    chk("R10 no req after warm-up", 32'(req), 32'h0);
    pin = 1'b0; step(5);
    chk("R3 falling ignored in rising mode", rdata, word(1'b0, 1'b0));

    // R2/R3/R4/R6 sweep over mode and direction
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        logic to, hit;
        to  = logic'(d);
        hit = (s == 1) ? to : ~to;
        sel = logic'(s);
        pin = ~to; step(5);
        clear_all(); step(1);
        pin = to; step(2);
        chk("R2 level after two edges", rdata, word(to, 1'b0));
        step(1);
        chk("R3 flag on selected edge", rdata, word(to, hit));
        chk("R3 req on selected edge", 32'(req), 32'(hit));
        step(4);
        chk("R4 flag holds", rdata, word(to, hit));
        ack = 1'b1; step(1); ack = 1'b0;
        chk("R6 ack drops req", 32'(req), 32'h0);
        chk("R6 ack keeps flag", rdata, word(to, hit));
        we = 1'b1; wdata = '0; step(1); we = 1'b0;
        chk("R4 clear-write drops flag", rdata, word(to, 1'b0));
      end
    end

    // R5/R8: writing ones never sets the flag nor reserved bits
    we = 1'b1; wdata = 32'hFFFF_FFFF; step(1); we = 1'b0;
    chk("R5 write one does not set flag", rdata, word(pin, 1'b0));

    // R7: clear-write keeps the request
    sel = 1'b1; pin = 1'b0; step(5); clear_all();
    pin = 1'b1; step(3);
    we = 1'b1; wdata = 32'h0; step(1); we = 1'b0;
    chk("R7 flag cleared", rdata, word(1'b1, 1'b0));
    chk("R7 req kept", 32'(req), 32'h1);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R7 req dropped by ack", 32'(req), 32'h0);

    // R9: event coinciding with clear-write
    pin = 1'b0; step(5); clear_all();
    pin = 1'b1; step(2);
    we = 1'b1; wdata = 32'h0; step(1); we = 1'b0;
    chk("R9 event beats clear", rdata, word(1'b1, 1'b1));

    // R9: event coinciding with ack
    pin = 1'b0; step(5);
    pin = 1'b1; step(2);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R9 event beats ack", 32'(req), 32'h1);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R9 later ack drops req", 32'(req), 32'h0);

    // R11: event with flag already set raises req
    chk("R11 flag still set", rdata, word(1'b1, 1'b1));
    pin = 1'b0; step(5);
    pin = 1'b1; step(3);
    chk("R11 req raised with flag set", 32'(req), 32'h1);

    // R8: all-ones write with flag set leaves only level and flag
    we = 1'b1; wdata = 32'hFFFF_FFFF; step(1); we = 1'b0;
    chk("R8 reserved bits zero", rdata, word(1'b1, 1'b1));
    we = 1'b1; wdata = 32'h7FFE_FFFF; step(1); we = 1'b0;
    chk("R8 reserved ignored, bit16 clears", rdata, word(1'b1, 1'b0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule